// File: doc/BRIEF.md
# Serial Codeword Transmitter with Sync Header and CRC-8

This block turns one parallel data chunk into a serial codeword on a single output wire. Each codeword has three parts. First comes a fixed 8-bit synchronization header, which lets a receiver find the bit boundaries. Next comes the data chunk. Last comes an 8-bit CRC computed over the chunk. Every bit stays on the wire for a programmable number of clock cycles. This suits a slow, unconnected link whose bit period is in the millisecond range.

A start request in the idle state captures the chunk and the bit period, then begins the codeword. If the far end reports a corrupt codeword, a resend request transmits the stored chunk and its CRC again. While the codeword is on the wire, the busy flag is high. A one-cycle done pulse marks the end of the codeword. The width of the data chunk is a parameter, and both 16 and 32 bits are supported.

The controller is a five-state machine:
- IDLE: the wire is low, and the block waits for a start or resend request.
- SYNC: the header bits are sent.
- DATA: the chunk bits are sent.
- CRC: the check bits are sent.
- DONE: a single cycle that raises the done pulse.

The transitions are:
- IDLE to SYNC on a start or resend request.
- SYNC to DATA after the eighth header bit.
- DATA to CRC after the last chunk bit.
- CRC to DONE after the eighth check bit.
- DONE to IDLE unconditionally.

Top module: `sync_crc_serializer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, tx_o, busy_o and done_o are all 0.
- R2: In IDLE, a high start_i is accepted at a clock edge, and busy_o is 1 from the next cycle on. The codeword opens with the header 1,0,1,0,1,1,0,0, sent in that order, so the first bit on the wire is 1.
- R3: Each codeword bit is held on tx_o for exactly P cycles. P is period_i as sampled at the accepting edge, and a value of 0 is treated as 1. Changes to period_i during a codeword have no effect.
- R4: After the header, the chunk is sent with its most significant bit first.
- R5: After the chunk, the CRC is sent with its most significant bit first. The CRC uses generator x^8+x^2+x+1 (0x07), starts from 0x00, takes chunk bits most significant first, and has no reflection and no final inversion.
- R6: In the cycle after the last CRC bit period, busy_o falls and done_o is 1 for exactly one cycle. done_o and busy_o are never high together.
- R7: While busy_o is 1, start_i and data_i are ignored. The codeword on the wire and the stored chunk stay unchanged.
- R8: In IDLE, resend_i without start_i retransmits the most recently accepted chunk with its CRC, using the period_i sampled at that edge. If start_i and resend_i are both high, the start request wins and the new chunk is sent.
- R9: tx_o is 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send a new chunk |
| data_i | input | DATA_W | Chunk captured with start_i |
| period_i | input | PERIOD_W | Bit period in clock cycles |
| resend_i | input | 1 | Request to resend the stored chunk |
| tx_o | output | 1 | Serial codeword output |
| busy_o | output | 1 | A codeword is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a codeword |

## Verification
The bench targets several corner cases:
- Periods of 0 and 1. A timer that is off by one would stretch or shorten every bit, or stall on a zero period.
- period_i and data_i changed in the middle of a codeword. A design that fails to latch them would corrupt the bits that follow.
- A start pulse injected while busy. A design that re-accepts it would restart the header or swap in the new chunk.
- A resend after that injection, and a start together with a resend. A wrong priority or a clobbered stored chunk would put the wrong data and CRC on the wire.
- All-zero and all-one chunks, with CRCs computed in the bench by polynomial division. A bit-order error or a wrong generator would send wrong check bits.

// File: rtl/sync_crc_serializer_pkg.sv
package sync_crc_serializer_pkg;

    localparam int HDR_W = 8;
    localparam int CHK_W = 8;
    localparam logic [HDR_W-1:0] HDR_PATTERN = 8'b1010_1100;
    localparam logic [CHK_W-1:0] CHK_POLY = 8'h07;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_CRC,
        ST_DONE
    } tx_state_t;

endpackage

// File: rtl/scs_crc8.sv
module scs_crc8
    import sync_crc_serializer_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] chunk_i,
    output logic [CHK_W-1:0]  crc_o
);

    logic [CHK_W-1:0] acc;
    logic             fb;

    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[CHK_W-1] ^ chunk_i[i];
            acc = {acc[CHK_W-2:0], 1'b0} ^ (fb ? CHK_POLY : '0);
        end
        crc_o = acc;
    end

endmodule

// File: rtl/scs_bit_timer.sv
module scs_bit_timer #(
    parameter int PERIOD_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                run_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                tick_o
);

    logic [PERIOD_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == period_i - PERIOD_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i || !run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PERIOD_W'(1);
        end
    end

endmodule

// File: rtl/scs_frame_shifter.sv
module scs_frame_shifter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               shift_i,
    output logic               msb_o
);

    logic [FRAME_W-1:0] sr_q;

    assign msb_o = sr_q[FRAME_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= frame_i;
        end else if (shift_i) begin
            sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/sync_crc_serializer.sv
module sync_crc_serializer
    import sync_crc_serializer_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PERIOD_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                resend_i,
    output logic                tx_o,
    output logic                busy_o,
    output logic                done_o
);

    localparam int FRAME_W = HDR_W + DATA_W + CHK_W;
    localparam int CNT_W   = $clog2(DATA_W);

    tx_state_t state_q, state_d;

    logic [DATA_W-1:0]   chunk_q;
    logic [CHK_W-1:0]    chk_q;
    logic [PERIOD_W-1:0] per_q;
    logic [CNT_W-1:0]    bit_q;

    logic                take_new, take_old, launch;
    logic [DATA_W-1:0]   chunk_sel;
    logic [CHK_W-1:0]    chk_new, chk_sel;
    logic                tick, last_bit, sending, line_bit;

    assign take_new  = (state_q == ST_IDLE) && start_i;
    assign take_old  = (state_q == ST_IDLE) && !start_i && resend_i;
    assign launch    = take_new || take_old;
    assign chunk_sel = take_new ? data_i  : chunk_q;
    assign chk_sel   = take_new ? chk_new : chk_q;
    assign sending   = (state_q == ST_SYNC) || (state_q == ST_DATA) || (state_q == ST_CRC);

    scs_crc8 #(.DATA_W(DATA_W)) u_crc (
        .chunk_i (data_i),
        .crc_o   (chk_new)
    );

    scs_bit_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (launch),
        .run_i    (sending),
        .period_i (per_q),
        .tick_o   (tick)
    );

    scs_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (launch),
        .frame_i ({HDR_PATTERN, chunk_sel, chk_sel}),
        .shift_i (tick),
        .msb_o   (line_bit)
    );

    // Chunk, check bits and period captured at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chunk_q <= '0;
            chk_q   <= '0;
            per_q   <= PERIOD_W'(1);
        end else if (launch) begin
            chunk_q <= chunk_sel;
            chk_q   <= chk_sel;
            per_q   <= (period_i == '0) ? PERIOD_W'(1) : period_i;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SYNC: last_bit = (bit_q == CNT_W'(HDR_W - 1));
            ST_DATA: last_bit = (bit_q == CNT_W'(DATA_W - 1));
            ST_CRC:  last_bit = (bit_q == CNT_W'(CHK_W - 1));
            default: last_bit = 1'b0;
        endcase
    end

    // Bit position within the current phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (launch) begin
            bit_q <= '0;
        end else if (tick) begin
            bit_q <= last_bit ? '0 : bit_q + CNT_W'(1);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)           state_d = ST_SYNC;
            ST_SYNC: if (tick && last_bit) state_d = ST_DATA;
            ST_DATA: if (tick && last_bit) state_d = ST_CRC;
            ST_CRC:  if (tick && last_bit) state_d = ST_DONE;
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o = 1'b0;
        done_o = 1'b0;
        tx_o   = 1'b0;
        unique case (state_q)
            ST_SYNC, ST_DATA, ST_CRC: begin
                busy_o = 1'b1;
                tx_o   = line_bit;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sync_crc_serializer_chk.sv
module sync_crc_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic resend_i,
    input logic tx_o,
    input logic busy_o,
    input logic done_o
);

    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !tx_o); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o)); // R6

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R6

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o && (start_i || resend_i)) |=> busy_o); // R2

    AST_FIRST_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> tx_o); // R2

endmodule

bind sync_crc_serializer sync_crc_serializer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .resend_i (resend_i),
    .tx_o     (tx_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/sync_crc_serializer_bench.sv
module sync_crc_serializer_bench;

    localparam int DW = 16;
    localparam int PW = 24;
    localparam int NB = 8 + DW + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic [PW-1:0] period_i = '0;
    logic          resend_i = 1'b0;
    logic          tx_o, busy_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sync_crc_serializer #(.DATA_W(DW), .PERIOD_W(PW)) u_sync_crc_serializer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
        .period_i(period_i), .resend_i(resend_i),
        .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
    );

    // Remainder of chunk * x^8 divided by 0x107
    function automatic logic [7:0] ref_crc(input logic [DW-1:0] d);
        logic [DW+7:0] r;
        r = {d, 8'h00};
        for (int i = DW + 7; i >= 8; i--) begin
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        end
        return r[7:0];
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Launch one codeword and compare every bit cycle; inject >= 0 pulses start mid-frame
    task automatic run_frame(input logic use_start, input logic use_resend,
                             input logic [DW-1:0] d, input int per, input int inject,
                             input logic [DW-1:0] exp_d);
        logic [NB-1:0] frame;
        int            p;
        string         tag;
        logic          first;
        logic          held;
        p     = (per == 0) ? 1 : per;
        frame = {8'b1010_1100, exp_d, ref_crc(exp_d)};
        start_i  = use_start;
        resend_i = use_resend;
        data_i   = d;
        period_i = PW'(per);
        @(negedge clk);
        start_i  = 1'b0;
        resend_i = 1'b0;
        period_i = PW'($urandom_range(1, 9));
        data_i   = DW'($urandom);
        check(busy_o === 1'b1, "R2 busy after accept", 32'(busy_o), 1);
        for (int b = 0; b < NB; b++) begin
            tag = (b < 8) ? "R2 header bit" : (b < 8 + DW) ? "R4 data bit" : "R5 crc bit";
            first = tx_o;
            check(first === frame[NB-1-b], $sformatf("%s %0d", tag, b), 32'(first),
                  32'(frame[NB-1-b]));
            if (b == inject) begin
                start_i = 1'b1;
                data_i  = ~exp_d;
            end
            held = 1'b1;
            for (int c = 1; c < p; c++) begin
                step();
                if (tx_o !== first) held = 1'b0;
            end
            check(held, $sformatf("R3 hold bit %0d", b), 32'(held), 1);
            step();
        end
        check(done_o === 1'b1, "R6 done pulse", 32'(done_o), 1);
        check(busy_o === 1'b0, "R6 busy falls", 32'(busy_o), 0);
        check(tx_o === 1'b0, "R9 line low after frame", 32'(tx_o), 0);
        @(negedge clk);
        check(done_o === 1'b0, "R6 done single cycle", 32'(done_o), 0);
        check(tx_o === 1'b0 && busy_o === 1'b0, "R9 idle line", 32'(tx_o), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] last;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check(tx_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1 in reset",
              {29'b0, tx_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1 after reset",
              {29'b0, tx_o, busy_o, done_o}, 0);

        // Directed corner cases
        run_frame(1, 0, 16'h0000, 0, -1, 16'h0000);   // R3 zero period as one
        run_frame(1, 0, 16'hFFFF, 1, -1, 16'hFFFF);   // R5 all ones
        run_frame(1, 0, 16'hA5C3, 3, 12, 16'hA5C3);   // R7 start while busy
        run_frame(0, 1, 16'h1234, 2, -1, 16'hA5C3);   // R8 resend keeps stored chunk
        run_frame(1, 1, 16'h5A0F, 2, -1, 16'h5A0F);   // R8 start wins
        run_frame(0, 1, 16'h0000, 4, 30, 16'h5A0F);   // R8 resend again, R7 late start

        // Random chunks and periods
        for (int k = 0; k < 24; k++) begin
            last = DW'($urandom);
            run_frame(1, 0, last, $urandom_range(0, 7),
                      ($urandom_range(0, 3) == 0) ? $urandom_range(0, NB - 1) : -1, last);
        end
        finish_run();
    end

endmodule